// File: doc/BRIEF.md
# Packet Interrupt Coalescing Unit

This unit sits beside one DMA channel and decides when finished packets should interrupt the processor. It runs two mechanisms side by side. A completion countdown is loaded from an 8-bit threshold and fires once the given number of packets has finished. A one-shot delay timer is loaded from an 8-bit delay and fires when no further packet has finished for that many ticks. The timer counts only on a tick-enable input, which comes from an external prescaler.

The channel's register block supplies two fields from its control register: the threshold from bits 23:16 and the delay from bits 31:24. It also supplies a strobe whenever that register is written. The DMA engine supplies a one-cycle pulse for each finished packet. The unit returns two one-cycle set pulses. The register block uses them to set its completion-interrupt flag (status bit 12) and its delay-interrupt flag (status bit 13). The unit also returns the live counter and timer values, so that status reads can show them. Flag storage and clearing are done outside this unit.

Top module: `coal_irq_unit`

## Requirements
- R1: After reset, `cnt_value` is 1, `tmr_value` is 0, and neither set pulse is high.
- R2: A cycle with `ctrl_wr` high loads the counter from `thr_field` at the next edge. If a packet also finishes in that cycle, it is not counted and gives no completion pulse.
- R3: With no control write, each `pkt_done` cycle decrements the counter. When the counter goes from 1 to 0, `cmpl_irq_set` is high for the one cycle after that edge, and the counter holds the threshold instead of 0.
- R4: A threshold of 0 gives a completion pulse after every 256 completions. The counter wraps from 0 to 255 when it decrements.
- R5: A `pkt_done` cycle with a non-zero `dly_field` loads the timer with `dly_field`. This happens whether the timer was running or stopped.
- R6: A `pkt_done` cycle with `dly_field` equal to 0 leaves the timer value unchanged, and any tick in that cycle is ignored.
- R7: When there is no completion, the timer decrements by one in each `tick_en` cycle while it is non-zero. Otherwise it holds. It stops at 0 and does not restart until the next completion.
- R8: A tick that moves the timer from 1 to 0, in a cycle with no completion, raises `dly_irq_set` for one cycle. It also reloads the counter from `thr_field`.
- R9: If a completion and a timer expiry fall in the same cycle, the completion wins. The timer is restarted or held as R5/R6 describe, no delay pulse is raised, and the counter decrements as R3 describes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_field | input | 8 | Completion threshold (control bits 23:16) |
| dly_field | input | 8 | Delay in ticks (control bits 31:24) |
| ctrl_wr | input | 1 | Control register write strobe |
| pkt_done | input | 1 | One-cycle packet completion pulse |
| tick_en | input | 1 | Prescaler tick enable for the timer |
| cmpl_irq_set | output | 1 | Set pulse for the completion-interrupt flag |
| dly_irq_set | output | 1 | Set pulse for the delay-interrupt flag |
| cnt_value | output | 8 | Live completion counter |
| tmr_value | output | 8 | Live delay timer |

## Verification
Two events can land in the same cycle: a packet completion and the timer's final tick. The bench provokes this by counting the timer down to 1 and then asserting `pkt_done` and `tick_en` together. It passes if the timer holds the reloaded delay, no delay pulse appears, and the counter takes its normal decrement, possibly with a completion pulse. Two related collisions are also driven. In one, a control write coincides with a completion. In the other, a zero-delay completion coincides with a tick.

// File: rtl/coal_pkg.sv
package coal_pkg;

  typedef enum logic [1:0] {
    CNT_HOLD   = 2'd0,
    CNT_RELOAD = 2'd1,
    CNT_DEC    = 2'd2
  } cnt_op_e;

  typedef enum logic [1:0] {
    TMR_HOLD = 2'd0,
    TMR_LOAD = 2'd1,
    TMR_DEC  = 2'd2
  } tmr_op_e;

endpackage

// File: rtl/coal_event_arb.sv
module coal_event_arb
  import coal_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int TMR_W = 8
) (
  input  logic             ctrl_wr,
  input  logic             pkt_done,
  input  logic             tick_en,
  input  logic [TMR_W-1:0] dly,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [TMR_W-1:0] tmr_q,
  output cnt_op_e          cnt_op,
  output tmr_op_e          tmr_op,
  output logic             hit,
  output logic             expire
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [TMR_W-1:0] TMR_ONE = TMR_W'(1);
  localparam logic [TMR_W-1:0] TMR_ZERO = '0;

  logic tmr_running;
  logic dly_nonzero;

  always_comb begin
    tmr_running = (tmr_q != TMR_ZERO);
    dly_nonzero = (dly != TMR_ZERO);

    // A completion owns the timer in its cycle; ticks are dropped.
    expire = !pkt_done && tick_en && (tmr_q == TMR_ONE);
    if (pkt_done) begin
      tmr_op = dly_nonzero ? TMR_LOAD : TMR_HOLD;
    end else if (tick_en && tmr_running) begin
      tmr_op = TMR_DEC;
    end else begin
      tmr_op = TMR_HOLD;
    end

    // A control write swallows a same-cycle completion.
    hit = pkt_done && !ctrl_wr && (cnt_q == CNT_ONE);
    if (ctrl_wr || expire || hit) begin
      cnt_op = CNT_RELOAD;
    end else if (pkt_done) begin
      cnt_op = CNT_DEC;
    end else begin
      cnt_op = CNT_HOLD;
    end
  end

endmodule

// File: rtl/coal_cmpl_counter.sv
module coal_cmpl_counter
  import coal_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int RST_COUNT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_op_e          cnt_op,
  input  logic [CNT_W-1:0] thr,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(RST_COUNT);

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = (cnt_op != CNT_HOLD);
    unique case (cnt_op)
      CNT_RELOAD: cnt_d = thr;
      CNT_DEC:    cnt_d = cnt_q - CNT_W'(1);
      default:    cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_RST;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/coal_delay_timer.sv
module coal_delay_timer
  import coal_pkg::*;
#(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_op_e          tmr_op,
  input  logic [TMR_W-1:0] dly,
  output logic [TMR_W-1:0] tmr_q
);

  logic [TMR_W-1:0] tmr_d;
  logic             tmr_en;

  always_comb begin
    tmr_en = (tmr_op != TMR_HOLD);
    unique case (tmr_op)
      TMR_LOAD: tmr_d = dly;
      TMR_DEC:  tmr_d = tmr_q - TMR_W'(1);
      default:  tmr_d = tmr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (tmr_en) begin
      tmr_q <= tmr_d;
    end
  end

endmodule

// File: rtl/coal_irq_unit.sv
module coal_irq_unit
  import coal_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int TMR_W     = 8,
  parameter int RST_COUNT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] thr_field,
  input  logic [TMR_W-1:0] dly_field,
  input  logic             ctrl_wr,
  input  logic             pkt_done,
  input  logic             tick_en,
  output logic             cmpl_irq_set,
  output logic             dly_irq_set,
  output logic [CNT_W-1:0] cnt_value,
  output logic [TMR_W-1:0] tmr_value
);

  cnt_op_e          cnt_op;
  tmr_op_e          tmr_op;
  logic             hit;
  logic             expire;
  logic [CNT_W-1:0] cnt_q;
  logic [TMR_W-1:0] tmr_q;
  logic             cmpl_q, cmpl_d;
  logic             dly_q, dly_d;

  coal_event_arb #(.CNT_W(CNT_W), .TMR_W(TMR_W)) i_arb (
    .ctrl_wr  (ctrl_wr),
    .pkt_done (pkt_done),
    .tick_en  (tick_en),
    .dly      (dly_field),
    .cnt_q    (cnt_q),
    .tmr_q    (tmr_q),
    .cnt_op   (cnt_op),
    .tmr_op   (tmr_op),
    .hit      (hit),
    .expire   (expire)
  );

  coal_cmpl_counter #(.CNT_W(CNT_W), .RST_COUNT(RST_COUNT)) i_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_op (cnt_op),
    .thr    (thr_field),
    .cnt_q  (cnt_q)
  );

  coal_delay_timer #(.TMR_W(TMR_W)) i_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .tmr_op (tmr_op),
    .dly    (dly_field),
    .tmr_q  (tmr_q)
  );

  always_comb begin
    cmpl_d = hit;
    dly_d  = expire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmpl_q <= 1'b0;
      dly_q  <= 1'b0;
    end else begin
      cmpl_q <= cmpl_d;
      dly_q  <= dly_d;
    end
  end

  assign cmpl_irq_set = cmpl_q;
  assign dly_irq_set  = dly_q;
  assign cnt_value    = cnt_q;
  assign tmr_value    = tmr_q;

endmodule

// File: rtl/coal_irq_unit_chk.sv
module coal_irq_unit_chk #(
  parameter int CNT_W = 8,
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] thr_field,
  input logic [TMR_W-1:0] dly_field,
  input logic             ctrl_wr,
  input logic             pkt_done,
  input logic             tick_en,
  input logic             cmpl_irq_set,
  input logic             dly_irq_set,
  input logic [CNT_W-1:0] cnt_value,
  input logic [TMR_W-1:0] tmr_value
);

  // R2
  write_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (cnt_value == $past(thr_field)) && !cmpl_irq_set);

  // R3
  cmpl_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && !ctrl_wr && cnt_value == CNT_W'(1)) |=> cmpl_irq_set);

  // R5
  delay_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && dly_field != '0) |=> (tmr_value == $past(dly_field)));

  // R6
  zero_delay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && dly_field == '0) |=> $stable(tmr_value));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_done && !tick_en) |=> $stable(tmr_value));

  // R8
  expire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pkt_done && tick_en && tmr_value == TMR_W'(1)) |=> dly_irq_set && (tmr_value == '0));

  // R9
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && tick_en && tmr_value == TMR_W'(1)) |=> !dly_irq_set);

endmodule

bind coal_irq_unit coal_irq_unit_chk #(.CNT_W(CNT_W), .TMR_W(TMR_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .thr_field    (thr_field),
  .dly_field    (dly_field),
  .ctrl_wr      (ctrl_wr),
  .pkt_done     (pkt_done),
  .tick_en      (tick_en),
  .cmpl_irq_set (cmpl_irq_set),
  .dly_irq_set  (dly_irq_set),
  .cnt_value    (cnt_value),
  .tmr_value    (tmr_value)
);

// File: tb/test_coal_irq_unit.sv
`timescale 1ns/1ps
module test_coal_irq_unit;

  logic       clk;
  logic       rst_n;
  logic [7:0] thr_field;
  logic [7:0] dly_field;
  logic       ctrl_wr;
  logic       pkt_done;
  logic       tick_en;
  logic       cmpl_irq_set;
  logic       dly_irq_set;
  logic [7:0] cnt_value;
  logic [7:0] tmr_value;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  coal_irq_unit i_coal_irq_unit (
    .clk          (clk),
    .rst_n        (rst_n),
    .thr_field    (thr_field),
    .dly_field    (dly_field),
    .ctrl_wr      (ctrl_wr),
    .pkt_done     (pkt_done),
    .tick_en      (tick_en),
    .cmpl_irq_set (cmpl_irq_set),
    .dly_irq_set  (dly_irq_set),
    .cnt_value    (cnt_value),
    .tmr_value    (tmr_value)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Entry: wr, thr, dly, pkt, tick | exp cnt, exp tmr, exp cmpl, exp dly
  localparam int NV = 15;
  localparam logic [36:0] VEC [NV] = '{
    {1'b1, 8'd3, 8'd2, 1'b0, 1'b0, 8'd3, 8'd0, 1'b0, 1'b0}, // R2 write
    {1'b0, 8'd3, 8'd2, 1'b1, 1'b0, 8'd2, 8'd2, 1'b0, 1'b0}, // R3 R5
    {1'b0, 8'd3, 8'd2, 1'b0, 1'b1, 8'd2, 8'd1, 1'b0, 1'b0}, // R7
    {1'b0, 8'd3, 8'd2, 1'b1, 1'b0, 8'd1, 8'd2, 1'b0, 1'b0}, // R5 restart
    {1'b0, 8'd3, 8'd2, 1'b0, 1'b1, 8'd1, 8'd1, 1'b0, 1'b0}, // R7
    {1'b0, 8'd3, 8'd2, 1'b1, 1'b1, 8'd3, 8'd2, 1'b1, 1'b0}, // R9 collision
    {1'b0, 8'd3, 8'd2, 1'b1, 1'b0, 8'd2, 8'd2, 1'b0, 1'b0}, // R3
    {1'b0, 8'd3, 8'd2, 1'b0, 1'b1, 8'd2, 8'd1, 1'b0, 1'b0}, // R7
    {1'b0, 8'd3, 8'd2, 1'b0, 1'b1, 8'd3, 8'd0, 1'b0, 1'b1}, // R8 expiry
    {1'b0, 8'd3, 8'd2, 1'b0, 1'b1, 8'd3, 8'd0, 1'b0, 1'b0}, // R7 one-shot
    {1'b0, 8'd3, 8'd0, 1'b1, 1'b0, 8'd2, 8'd0, 1'b0, 1'b0}, // R6 stopped
    {1'b0, 8'd3, 8'd5, 1'b1, 1'b0, 8'd1, 8'd5, 1'b0, 1'b0}, // R5
    {1'b0, 8'd3, 8'd0, 1'b1, 1'b1, 8'd3, 8'd5, 1'b1, 1'b0}, // R6 tick dropped
    {1'b1, 8'd7, 8'd0, 1'b1, 1'b0, 8'd7, 8'd5, 1'b0, 1'b0}, // R2 swallows pkt
    {1'b0, 8'd7, 8'd0, 1'b0, 1'b0, 8'd7, 8'd5, 1'b0, 1'b0}  // R7 hold
  };

  task automatic check(input string req, input string what,
                       input int actual, input int expected);
    n_checks++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic drive(input bit wr, input int thr, input int dly,
                       input bit pkt, input bit tick);
    ctrl_wr   = wr;
    thr_field = 8'(thr);
    dly_field = 8'(dly);
    pkt_done  = pkt;
    tick_en   = tick;
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int cmpl_seen;
    rst_n = 1'b0;
    drive(1'b0, 0, 0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "cnt_value", int'(cnt_value), 1);
    check("R1", "tmr_value", int'(tmr_value), 0);
    check("R1", "cmpl_irq_set", int'(cmpl_irq_set), 0);
    check("R1", "dly_irq_set", int'(dly_irq_set), 0);

    // Table walk covering R2 R3 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][36], int'(VEC[i][35:28]), int'(VEC[i][27:20]),
            VEC[i][19], VEC[i][18]);
      @(negedge clk);
      check("R2_R3_R5_R6_R7_R8_R9 table", $sformatf("vec %0d cnt", i),
            int'(cnt_value), int'(VEC[i][17:10]));
      check("R2_R3_R5_R6_R7_R8_R9 table", $sformatf("vec %0d tmr", i),
            int'(tmr_value), int'(VEC[i][9:2]));
      check("R2_R3_R5_R6_R7_R8_R9 table", $sformatf("vec %0d cmpl", i),
            int'(cmpl_irq_set), int'(VEC[i][1]));
      check("R2_R3_R5_R6_R7_R8_R9 table", $sformatf("vec %0d dly", i),
            int'(dly_irq_set), int'(VEC[i][0]));
    end

    // R8: delay of 1, expiry reloads a partly consumed counter
    drive(1'b1, 2, 1, 1'b0, 1'b0);
    @(negedge clk);
    drive(1'b0, 2, 1, 1'b1, 1'b0);
    @(negedge clk);
    check("R8", "cnt before expiry", int'(cnt_value), 1);
    check("R5", "tmr after load of 1", int'(tmr_value), 1);
    drive(1'b0, 2, 1, 1'b0, 1'b1);
    @(negedge clk);
    check("R8", "dly pulse", int'(dly_irq_set), 1);
    check("R8", "cnt reloaded", int'(cnt_value), 2);
    drive(1'b0, 2, 1, 1'b0, 1'b0);
    @(negedge clk);
    check("R8", "dly pulse one cycle", int'(dly_irq_set), 0);

    // R4: threshold 0 means 256 completions per pulse
    drive(1'b1, 0, 0, 1'b0, 1'b0);
    @(negedge clk);
    check("R4", "cnt after zero threshold", int'(cnt_value), 0);
    cmpl_seen = 0;
    for (int k = 0; k < 255; k++) begin
      drive(1'b0, 0, 0, 1'b1, 1'b0);
      @(negedge clk);
      cmpl_seen += int'(cmpl_irq_set);
    end
    check("R4", "pulses in 255 completions", cmpl_seen, 0);
    check("R4", "cnt after 255", int'(cnt_value), 1);
    drive(1'b0, 0, 0, 1'b1, 1'b0);
    @(negedge clk);
    check("R4", "pulse on 256th", int'(cmpl_irq_set), 1);
    check("R4", "cnt after wrap", int'(cnt_value), 0);

    // R3: threshold 1 pulses on every completion
    drive(1'b1, 1, 0, 1'b0, 1'b0);
    @(negedge clk);
    for (int k = 0; k < 3; k++) begin
      drive(1'b0, 1, 0, 1'b1, 1'b0);
      @(negedge clk);
      check("R3", $sformatf("thr1 pulse %0d", k), int'(cmpl_irq_set), 1);
      check("R3", $sformatf("thr1 cnt %0d", k), int'(cnt_value), 1);
    end
    drive(1'b0, 1, 0, 1'b0, 1'b0);
    @(negedge clk);
    check("R3", "pulse drops", int'(cmpl_irq_set), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule